// File: doc/BRIEF.md
# Decoded Radio Data Block Buffer with Host Read Request

This block sits between the block decoder of a broadcast radio data receiver and the serial host port. Every decoded block arrives as 16 data bits with its flags (offset-word code, error count, traffic-key indicator) and is kept, together with the synchronization state at the moment of receipt, in a ring of up to 24 entries. The host is told through an active-low request line that data is waiting. It then shifts the head entry out bit by bit while its chip-enable is high.

Writes depend on the synchronization state. While a sync reset is held, the buffer and the staging area are cleared and incoming blocks are dropped. After the reset is released, blocks are kept in a small staging area (the backward-protection window) until synchronization is found. At that moment they all become readable at once. In normal running, blocks received out of sync are kept only when the write-unsynchronized control is set.

The request line is driven by a state machine with five states. WAIT_SYNC is entered on reset and on sync reset, and is left to IDLE when sync is found. IDLE moves to ASK when the fill reaches the threshold. IDLE or ASK moves to READ when chip-enable rises. READ moves to GAP when chip-enable falls. GAP moves to ASK if data remains, or to IDLE if the buffer is empty, after GAP_CYCLES cycles. From GAP, a new read goes back to READ. Any state moves to WAIT_SYNC while sync reset is high. The request line is low only in ASK.

Top module: `rds_blk_buffer`

## Requirements
- R1: The buffer holds at most 24 entries. A write to a full buffer with no pop in the same cycle discards the oldest entry, and the fill count stays at 24. A write and a final-bit pop in the same cycle of a full buffer leave the count at 24 and lose no entry.
- R2: rd_word has this layout: [26] more, [25:24] fill code, [23:21] offset code, [20] sync flag at receipt, [19] traffic-key flag, [18:16] error count, [15:0] data. rd_word is all zeros when the buffer is empty.
- R3: The fill code gives the entries remaining, counting the head. Code 00 means 1 to 7, 01 means 8 to 15, 10 means 16 to 23 and 11 means 24. The more bit is 1 when at least one other entry follows the head.
- R4: In IDLE, req_n goes low once the fill reaches the threshold selected by req_thr: 00 means 1, 01 means 4, 10 means 8, 11 means 12.
- R5: After rd_en falls, req_n is held high for GAP_CYCLES cycles. It then goes low if any entry remains, even below the threshold. Otherwise it stays high until the threshold is reached.
- R6: Outside the staging window, a block with in_sync=1 is stored. A block with in_sync=0 is stored only when wr_unsync=1, and its sync flag is 0.
- R7: While sync_rst is high, the buffer and the staging area are emptied, blocks are ignored and req_n is high. After release, req_n stays high until in_sync is seen.
- R8: Blocks that arrive between the sync reset and sync are staged, and only the latest 4 are kept. When in_sync is seen, the staged blocks become readable in arrival order. A block that arrives in that same cycle is included last.
- R9: 27 rd_bit pulses with rd_en high consume the head entry. If rd_en falls after fewer bits, the entry is read again from the start by the next readout. The exception is 26 bits: in that case the entry counts as consumed.
- R10: req_n is high in every cycle that follows a cycle with rd_en high.
- R11: After rst_n, the buffer is empty, rd_word is zero, req_n is high, and the block behaves as after a sync reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_valid | input | 1 | One-cycle strobe: a decoded block is present |
| blk_data | input | 16 | Block data bits |
| blk_ofs | input | 3 | Offset-word code of the block |
| blk_err | input | 3 | Error count or uncorrectable code |
| blk_ari | input | 1 | Traffic-key signal detected |
| in_sync | input | 1 | Current block synchronization state |
| sync_rst | input | 1 | Sync reset, active high |
| wr_unsync | input | 1 | Also store blocks received out of sync |
| req_thr | input | 2 | Request fill threshold select |
| rd_en | input | 1 | Host readout active (chip enable) |
| rd_bit | input | 1 | One bit of the head word shifted out |
| rd_word | output | 27 | Head entry with status fields |
| req_n | output | 1 | Active-low read request |

## Verification
Two pairs of events can fall in the same cycle: the pop on the final bit of a word and the write of a new block, and the commit of the staged blocks and the arrival of a further block. The first pair is provoked by strobing blk_valid during the 27th rd_bit pulse while the buffer is full. The result is judged by the fill code staying at 11 and the next head being the expected entry. The second pair is provoked by raising in_sync together with blk_valid after a sync reset. The result is judged by reading back all staged blocks followed by the new one, with the correct remaining counts.

// File: rtl/rbuf_pkg.sv
package rbuf_pkg;

    // Stored part of an entry; field order matches rd_word[23:0]
    typedef struct packed {
        logic [2:0]  ofs;
        logic        syn;
        logic        ari;
        logic [2:0]  err;
        logic [15:0] data;
    } entry_t;

    localparam int ENTRY_W = $bits(entry_t);
    localparam int WORD_W  = ENTRY_W + 3;

    typedef enum logic [2:0] {
        RQ_WAIT_SYNC,
        RQ_IDLE,
        RQ_ASK,
        RQ_READ,
        RQ_GAP
    } rq_state_t;

    function automatic int thr_blocks(input logic [1:0] sel);
        case (sel)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 12;
        endcase
    endfunction

endpackage

// File: rtl/blk_store.sv
module blk_store
    import rbuf_pkg::*;
#(
    parameter int DEPTH     = 24,
    parameter int STG_DEPTH = 4,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1),
    localparam int SW = $clog2(STG_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          stage,
    input  logic          commit,
    input  logic          pop,
    input  entry_t        wr_entry,
    output entry_t        head,
    output logic [CW-1:0] count
);

    entry_t        mem [DEPTH];
    logic [PW-1:0] rptr, wptr;
    logic [SW-1:0] pend;
    logic          pop_ok, full, drop_stage, drop_full;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign pop_ok     = pop && (count != '0);
    assign full       = (count == CW'(DEPTH));
    assign drop_stage = stage && !commit && (pend == SW'(STG_DEPTH));
    assign drop_full  = push && full && !pop_ok;
    assign head       = mem[rptr];

    always_ff @(posedge clk) begin
        if (!flush && (push || stage))
            mem[wptr] <= wr_entry;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rptr  <= '0;
            wptr  <= '0;
            pend  <= '0;
            count <= '0;
        end else if (flush) begin
            rptr  <= '0;
            wptr  <= '0;
            pend  <= '0;
            count <= '0;
        end else begin
            if (push || stage)
                wptr <= step(wptr);
            if (pop_ok || drop_stage || drop_full)
                rptr <= step(rptr);
            if (commit) begin
                count <= CW'(pend) + CW'(stage);
                pend  <= '0;
            end else begin
                if (stage && !drop_stage)
                    pend <= pend + 1'b1;
                count <= count + CW'(push && !drop_full) - CW'(pop_ok);
            end
        end
    end

    // R1
    cnt_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R1
    full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !flush) |=> (count == CW'(DEPTH)));

    // R7
    flush_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));

endmodule

// File: rtl/rd_seq.sv
module rd_seq #(
    parameter int W = 27,
    localparam int BW = $clog2(W + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_en,
    input  logic rd_bit,
    output logic pop
);

    logic [BW-1:0] bitcnt;
    logic          at_last;

    assign at_last = (bitcnt == BW'(W - 1));
    // full word shifted, or readout ended with only the final bit outstanding
    assign pop = at_last && (rd_en ? rd_bit : 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bitcnt <= '0;
        else if (!rd_en)
            bitcnt <= '0;
        else if (rd_bit)
            bitcnt <= at_last ? '0 : bitcnt + 1'b1;
    end

endmodule

// File: rtl/req_fsm.sv
module req_fsm
    import rbuf_pkg::*;
#(
    parameter int GAP_CYCLES = 64,
    parameter int CW         = 5,
    localparam int GW = $clog2(GAP_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_rst,
    input  logic          in_sync,
    input  logic          rd_en,
    input  logic [CW-1:0] count,
    input  logic [1:0]    thr,
    output logic          req_n,
    output logic          waiting
);

    rq_state_t     st, nxt;
    logic [GW-1:0] gap_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= RQ_WAIT_SYNC;
            gap_cnt <= '0;
        end else begin
            st      <= nxt;
            gap_cnt <= (st == RQ_GAP) ? gap_cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        nxt = st;
        unique case (st)
            RQ_WAIT_SYNC: if (in_sync) nxt = RQ_IDLE;
            RQ_IDLE: begin
                if (rd_en)                                nxt = RQ_READ;
                else if (int'(count) >= thr_blocks(thr))  nxt = RQ_ASK;
            end
            RQ_ASK: begin
                if (rd_en)               nxt = RQ_READ;
                else if (count == '0)    nxt = RQ_IDLE;
            end
            RQ_READ: if (!rd_en) nxt = RQ_GAP;
            RQ_GAP: begin
                if (rd_en)
                    nxt = RQ_READ;
                else if (gap_cnt == GW'(GAP_CYCLES - 1))
                    nxt = (count != '0) ? RQ_ASK : RQ_IDLE;
            end
            default: nxt = RQ_WAIT_SYNC;
        endcase
        if (sync_rst)
            nxt = RQ_WAIT_SYNC;
    end

    always_comb begin
        req_n   = (st != RQ_ASK);
        waiting = (st == RQ_WAIT_SYNC);
    end

    // R10
    read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> req_n);

    // R7
    rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_rst |=> req_n);

endmodule

// File: rtl/rds_blk_buffer.sv
module rds_blk_buffer
    import rbuf_pkg::*;
#(
    parameter int DEPTH      = 24,
    parameter int STG_DEPTH  = 4,
    parameter int GAP_CYCLES = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_valid,
    input  logic [15:0]       blk_data,
    input  logic [2:0]        blk_ofs,
    input  logic [2:0]        blk_err,
    input  logic              blk_ari,
    input  logic              in_sync,
    input  logic              sync_rst,
    input  logic              wr_unsync,
    input  logic [1:0]        req_thr,
    input  logic              rd_en,
    input  logic              rd_bit,
    output logic [WORD_W-1:0] rd_word,
    output logic              req_n
);

    entry_t        wr_entry, head;
    logic [CW-1:0] count;
    logic          waiting, push, stage, commit, pop;
    logic [1:0]    fill_code;

    assign wr_entry = '{ofs: blk_ofs, syn: in_sync, ari: blk_ari,
                        err: blk_err, data: blk_data};
    assign stage  = blk_valid && !sync_rst && waiting;
    assign push   = blk_valid && !sync_rst && !waiting && (in_sync || wr_unsync);
    assign commit = waiting && in_sync && !sync_rst;

    blk_store #(.DEPTH(DEPTH), .STG_DEPTH(STG_DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(sync_rst), .push(push),
        .stage(stage), .commit(commit), .pop(pop), .wr_entry(wr_entry),
        .head(head), .count(count)
    );

    rd_seq #(.W(WORD_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_bit(rd_bit), .pop(pop)
    );

    req_fsm #(.GAP_CYCLES(GAP_CYCLES), .CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sync_rst(sync_rst), .in_sync(in_sync),
        .rd_en(rd_en), .count(count), .thr(req_thr), .req_n(req_n),
        .waiting(waiting)
    );

    always_comb begin
        if (count >= CW'(DEPTH))    fill_code = 2'b11;
        else if (count >= CW'(16))  fill_code = 2'b10;
        else if (count >= CW'(8))   fill_code = 2'b01;
        else                        fill_code = 2'b00;
    end

    assign rd_word = (count == '0) ? '0 : {count > CW'(1), fill_code, head};

    // R11
    boot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_rst || !in_sync && waiting) |=> req_n);

endmodule

// File: tb/test_rds_blk_buffer.sv
module test_rds_blk_buffer;

    localparam int W   = 27;
    localparam int GAP = 64;

    logic        clk = 0, rst_n = 0;
    logic        blk_valid = 0, blk_ari = 0, in_sync = 0, sync_rst = 0;
    logic        wr_unsync = 0, rd_en = 0, rd_bit = 0;
    logic [15:0] blk_data = 0;
    logic [2:0]  blk_ofs = 0, blk_err = 0;
    logic [1:0]  req_thr = 0;
    logic [W-1:0] rd_word;
    logic        req_n;

    int checks = 0, errors = 0;
    bit done = 0;
    bit b_wait = 1;
    logic [23:0] exp_q[$];
    logic [23:0] stg_q[$];

    rds_blk_buffer #(.DEPTH(24), .STG_DEPTH(4), .GAP_CYCLES(GAP)) i_rds_blk_buffer (
        .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_data(blk_data),
        .blk_ofs(blk_ofs), .blk_err(blk_err), .blk_ari(blk_ari),
        .in_sync(in_sync), .sync_rst(sync_rst), .wr_unsync(wr_unsync),
        .req_thr(req_thr), .rd_en(rd_en), .rd_bit(rd_bit),
        .rd_word(rd_word), .req_n(req_n)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    function automatic logic [W-1:0] exp_word();
        int n = exp_q.size();
        logic [1:0] code;
        if (n == 0) return '0;
        code = (n >= 24) ? 2'd3 : (n >= 16) ? 2'd2 : (n >= 8) ? 2'd1 : 2'd0;
        return {n > 1, code, exp_q[0]};
    endfunction

    // driver: presents a block and pushes what should be kept into the queue
    task automatic write_blk(input logic [15:0] d, input logic [2:0] o,
                             input logic [2:0] e, input logic a, input bit sync_now);
        logic [23:0] ent;
        @(negedge clk);
        if (sync_now) in_sync = 1;
        blk_valid = 1; blk_data = d; blk_ofs = o; blk_err = e; blk_ari = a;
        ent = {o, in_sync, a, e, d};
        if (!sync_rst) begin
            if (b_wait) begin
                if (in_sync) begin
                    exp_q = stg_q; exp_q.push_back(ent); stg_q.delete(); b_wait = 0;
                end else begin
                    stg_q.push_back(ent);
                    if (stg_q.size() > 4) void'(stg_q.pop_front());
                end
            end else if (in_sync || wr_unsync) begin
                if (exp_q.size() == 24) void'(exp_q.pop_front());
                exp_q.push_back(ent);
            end
        end
        @(negedge clk);
        blk_valid = 0;
    endtask

    task automatic set_sync(input logic v);
        @(negedge clk);
        in_sync = v;
        if (v && b_wait) begin
            exp_q = stg_q; stg_q.delete(); b_wait = 0;
        end
        @(negedge clk);
    endtask

    // monitor side: compares the head word against the queue front
    task automatic read_seq(input int nfull, input int tail, input string req);
        @(negedge clk);
        rd_en = 1;
        @(negedge clk);
        chk("R10 request high during read", {31'd0, req_n}, 32'd1);
        for (int w = 0; w < nfull; w++) begin
            chk(req, {5'd0, rd_word}, {5'd0, exp_word()});
            rd_bit = 1;
            repeat (W) @(negedge clk);
            rd_bit = 0;
            if (exp_q.size() > 0) void'(exp_q.pop_front());
        end
        chk(req, {5'd0, rd_word}, {5'd0, exp_word()});
        if (tail > 0) begin
            rd_bit = 1;
            repeat (tail) @(negedge clk);
            rd_bit = 0;
        end
        rd_en = 0;
        @(negedge clk);
        if (tail == W - 1 && exp_q.size() > 0) void'(exp_q.pop_front());
    endtask

    task automatic gap_check(input bit expect_low);
        repeat (58) @(negedge clk);
        chk("R5 held high in gap", {31'd0, req_n}, 32'd1);
        repeat (12) @(negedge clk);
        chk("R5 after gap", {31'd0, req_n}, {31'd0, !expect_low});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk("R11 req_n after reset", {31'd0, req_n}, 32'd1);
        chk("R11 empty word after reset", {5'd0, rd_word}, 32'd0);

        // R8 staging keeps the latest four, R7 request waits for sync
        for (int i = 1; i <= 5; i++)
            write_blk(16'h1000 + 16'(i), 3'(i), 3'd0, 1'b0, 0);
        repeat (3) @(negedge clk);
        chk("R7 high until sync", {31'd0, req_n}, 32'd1);
        set_sync(1);
        repeat (2) @(negedge clk);
        chk("R8 commit raises request", {31'd0, req_n}, 32'd0);
        read_seq(4, 0, "R8 R2 R3 staged readout and empty zero");
        gap_check(0);

        // R4 threshold of eight
        req_thr = 2'b10;
        for (int i = 0; i < 7; i++)
            write_blk(16'h2100 + 16'(i), 3'd4, 3'd1, 1'b1, 0);
        repeat (3) @(negedge clk);
        chk("R4 below threshold", {31'd0, req_n}, 32'd1);
        write_blk(16'h2107, 3'd2, 3'd6, 1'b0, 0);
        repeat (3) @(negedge clk);
        chk("R4 threshold reached", {31'd0, req_n}, 32'd0);

        // R9 interrupted readouts
        read_seq(1, 10, "R9 R3 first word");
        gap_check(1);
        read_seq(0, 26, "R9 restart same entry");
        gap_check(1);
        read_seq(6, 0, "R9 R3 after final-bit consume");
        repeat (70) @(negedge clk);
        chk("R4 R5 empty after drain", {31'd0, req_n}, 32'd1);

        // R6 write gating
        req_thr = 2'b00;
        set_sync(0);
        write_blk(16'hBAD0, 3'd1, 3'd0, 1'b0, 0);
        repeat (3) @(negedge clk);
        chk("R6 unsynced block dropped", {5'd0, rd_word}, 32'd0);
        chk("R6 no request", {31'd0, req_n}, 32'd1);
        wr_unsync = 1;
        write_blk(16'h5A5A, 3'd3, 3'd2, 1'b1, 0);
        repeat (3) @(negedge clk);
        read_seq(1, 0, "R6 unsynced block kept");
        repeat (70) @(negedge clk);
        wr_unsync = 0;

        // R1 overflow drops oldest
        set_sync(1);
        for (int i = 0; i < 30; i++)
            write_blk(16'h3000 + 16'(i), 3'd5, 3'd0, 1'b0, 0);
        @(negedge clk);
        chk("R1 R3 full head word", {5'd0, rd_word}, {5'd0, exp_word()});

        // R1 pop and write in the same cycle while full
        rd_en = 1;
        @(negedge clk);
        rd_bit = 1;
        repeat (W - 1) @(negedge clk);
        blk_valid = 1; blk_data = 16'h4444; blk_ofs = 3'd0; blk_err = 3'd3; blk_ari = 0;
        @(negedge clk);
        rd_bit = 0; blk_valid = 0;
        void'(exp_q.pop_front());
        exp_q.push_back({3'd0, 1'b1, 1'b0, 3'd3, 16'h4444});
        chk("R1 R3 coincident pop and write", {5'd0, rd_word}, {5'd0, exp_word()});
        rd_en = 0;
        repeat (70) @(negedge clk);

        // R7 sync reset flushes and ignores blocks
        @(negedge clk);
        sync_rst = 1; in_sync = 0;
        exp_q.delete(); stg_q.delete(); b_wait = 1;
        write_blk(16'hDEAD, 3'd1, 3'd1, 1'b1, 0);
        @(negedge clk);
        sync_rst = 0;
        @(negedge clk);
        chk("R7 flushed word", {5'd0, rd_word}, 32'd0);
        chk("R7 request high", {31'd0, req_n}, 32'd1);

        // R8 commit together with a new block
        write_blk(16'h6001, 3'd0, 3'd0, 1'b0, 0);
        write_blk(16'h6002, 3'd1, 3'd5, 1'b1, 0);
        chk("R8 staged not readable", {5'd0, rd_word}, 32'd0);
        write_blk(16'h6003, 3'd2, 3'd0, 1'b0, 1);
        repeat (2) @(negedge clk);
        chk("R8 request after commit", {31'd0, req_n}, 32'd0);
        read_seq(3, 0, "R8 R3 commit with same-cycle block");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule